// File: doc/BRIEF.md
# Serial Star-Pattern Recognizer

This block is a clocked finite-state machine that reads one serial bit on every clock edge. It raises a single-cycle detect pulse when the bits received so far end in the regular language `10(110)*01`. That language is a leading `10`, then any number of `110` groups (including none), then a closing `01`. The repeated middle group has no bound, so the state graph loops back on itself instead of counting a fixed string length.

The state is held in D flip-flops. Matches may overlap. After a hit or a broken partial match, the machine carries on from the longest tail of the received bits that can still begin the pattern.

There is no back-pressure. The input has no valid or ready qualifier, and a new bit is consumed on every rising clock edge that is not in reset. The detect output is a plain registered status pin.

Top module: `kleene_seq_detect`

## Requirements
- R1: While `rst` is high at a rising edge, the machine returns to idle, and `detect_o` is 0 in the cycle that follows.
- R2: The stream `1001`, with no middle group, sets `detect_o` to 1 right after the edge that samples its final `1`.
- R3: Streams with one or more `110` groups between `10` and `01` are detected on their final bit. Examples are three groups (`1011011011001`) and thirty groups.
- R4: `detect_o` is high for exactly one cycle per completed match. It is 0 after every bit that does not complete one.
- R5: Matches overlap. After `1001`, the further bits `001` produce a second detect on the seventh bit.
- R6: A broken partial match restarts from the longest usable tail. For example, `10111001` is detected on its eighth bit.
- R7: After each sampled bit, `detect_o` is 1 exactly when the bits seen since the last reset end in a string of the language `10(110)*01`.
- R8: A reset in the middle of a pattern discards the history. `100`, then a reset, then `1` gives no detect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock. One bit is sampled per edge. |
| rst | input | 1 | Synchronous reset, active high. |
| data_i | input | 1 | Serial input bit. |
| detect_o | output | 1 | Registered pulse: the last bit completed the pattern. |

## Verification
The hardest situation to reach is a long run of repeated `110` groups that is then closed by `01`, or broken partway through. Random fair bits rarely build more than two groups in a row. The bench therefore drives directed streams with three and with thirty groups. It also drives a long random stream biased towards ones, which makes the loop states and their exits common. Every bit is compared against a behavioural matcher that tests every suffix of the recorded history against the language.

// File: rtl/kleene_seq_pkg.sv
package kleene_seq_pkg;
  localparam int STATE_W = 3;

  // ST_PRE:    history ends in 10 or in 10(110)+ (ready for 01 or 110)
  // ST_TAIL0:  first 0 of the closing 01 seen
  // ST_LOOP1:  one 1 of a 110 group seen
  // ST_LOOP11: two 1s of a 110 group seen
  // ST_HIT:    pattern just completed
  typedef enum logic [STATE_W-1:0] {
    ST_IDLE   = 3'd0,
    ST_ONE    = 3'd1,
    ST_PRE    = 3'd2,
    ST_TAIL0  = 3'd3,
    ST_LOOP1  = 3'd4,
    ST_LOOP11 = 3'd5,
    ST_HIT    = 3'd6
  } seq_state_t;
endpackage

// File: rtl/kleene_seq_next.sv
module kleene_seq_next
  import kleene_seq_pkg::*;
(
  input  seq_state_t cur,
  input  logic       bit_i,
  output seq_state_t nxt
);
  always_comb begin
    case (cur)
      ST_IDLE:   nxt = bit_i ? ST_ONE    : ST_IDLE;
      ST_ONE:    nxt = bit_i ? ST_ONE    : ST_PRE;
      ST_PRE:    nxt = bit_i ? ST_LOOP1  : ST_TAIL0;
      ST_TAIL0:  nxt = bit_i ? ST_HIT    : ST_IDLE;
      ST_LOOP1:  nxt = bit_i ? ST_LOOP11 : ST_PRE;
      ST_LOOP11: nxt = bit_i ? ST_ONE    : ST_PRE;
      ST_HIT:    nxt = bit_i ? ST_ONE    : ST_PRE;
      default:   nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/kleene_seq_reg.sv
module kleene_seq_reg
  import kleene_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_state_t nxt,
  output seq_state_t cur,
  output logic       hit_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur   <= ST_IDLE;
      hit_q <= 1'b0;
    end else begin
      cur   <= nxt;
      hit_q <= (nxt == ST_HIT);
    end
  end
endmodule

// File: rtl/kleene_seq_detect.sv
module kleene_seq_detect
  import kleene_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic data_i,
  output logic detect_o
);
  seq_state_t cur_s;
  seq_state_t nxt_s;
  logic       hit_s;

  kleene_seq_next u_next (
    .cur   (cur_s),
    .bit_i (data_i),
    .nxt   (nxt_s)
  );

  kleene_seq_reg u_reg (
    .clk   (clk),
    .rst   (rst),
    .nxt   (nxt_s),
    .cur   (cur_s),
    .hit_q (hit_s)
  );

  assign detect_o = hit_s;
endmodule

// File: rtl/kleene_seq_chk.sv
module kleene_seq_chk (
  input logic clk,
  input logic rst,
  input logic bit_in,
  input logic hit
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !hit); // R1

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit); // R4

  AST_ENDS_001: assert property (@(posedge clk) disable iff (rst)
    hit |-> ($past(bit_in) && !$past(bit_in, 2) && !$past(bit_in, 3))); // R2

  AST_PREFIX_BIT: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(bit_in, 4) || $past(bit_in, 5)); // R3
endmodule

bind kleene_seq_detect kleene_seq_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .bit_in (data_i),
  .hit    (detect_o)
);

// File: tb/kleene_seq_detect_test.sv
`timescale 1ns/1ps
module kleene_seq_detect_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic det;
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 0;
  bit   hist[$];

  always #2 clk = ~clk;

  kleene_seq_detect uut (.clk(clk), .rst(rst), .data_i(din), .detect_o(det));

  function automatic bit model_hit();
    int n = hist.size();
    for (int len = 4; len <= n; len += 3) begin
      int b = n - len;
      bit ok = (hist[b] == 1) && (hist[b+1] == 0) &&
               (hist[n-2] == 0) && (hist[n-1] == 1);
      for (int g = 0; g < (len - 4) / 3; g++) begin
        ok = ok && hist[b+2+3*g] && hist[b+3+3*g] && !hist[b+4+3*g];
      end
      if (ok) return 1;
    end
    return 0;
  endfunction

  task automatic check(string req, bit got, bit exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s detect=%0b expected=%0b", req, got, exp);
    end
  endtask

  task automatic step(bit b, string req);
    din = b;
    @(posedge clk);
    hist.push_back(b);
    if (hist.size() > 256) void'(hist.pop_front());
    @(negedge clk);
    check(req, det, model_hit());
  endtask

  task automatic do_reset(string req);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    hist.delete();
    check(req, det, 1'b0);
  endtask

  task automatic send_str(string s, string req);
    for (int i = 0; i < s.len(); i++) step(s[i] == "1", req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    do_reset("R1");
    send_str("100", "R4");
    step(1'b1, "R2");
    check("R2", det, 1'b1);
    step(1'b0, "R4");
    check("R4", det, 1'b0);

    do_reset("R1");
    send_str("101101101100", "R4");
    step(1'b1, "R3");
    check("R3", det, 1'b1);

    do_reset("R1");
    send_str("10", "R3");
    for (int g = 0; g < 30; g++) send_str("110", "R3");
    step(1'b0, "R3");
    step(1'b1, "R3");
    check("R3", det, 1'b1);

    do_reset("R1");
    send_str("1001001", "R5");
    check("R5", det, 1'b1);

    do_reset("R1");
    send_str("10111001", "R6");
    check("R6", det, 1'b1);

    do_reset("R1");
    send_str("100", "R8");
    do_reset("R8");
    step(1'b1, "R8");
    check("R8", det, 1'b0);

    do_reset("R1");
    send_str("0010100101101101100110010111", "R7");
    for (int i = 0; i < 3000; i++) step($urandom_range(0, 2) != 0, "R7");
    for (int i = 0; i < 3000; i++) step($urandom_range(0, 1) == 1, "R7");
    finish_run();
  end
endmodule